// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block times the high and low intervals of an already demodulated infrared envelope. The asynchronous input is synchronised and passed through a minimum-width glitch filter. A prescaled pulse-width timer then measures the time between selected edges. Each finished measurement goes into a small hardware FIFO, which a processor drains through a 32-bit valid/ready read port.

The prescaler reloads from `clk_div` and counts down. Each time it reaches zero, the timer advances by one, so the timer steps once every `clk_div+1` clocks. An entry keeps only the timer bits above the two least significant ones, together with the level of the interval it measured. When the timer runs past its maximum, the measurement stops and a timeout is flagged. An all-ones marker entry can also be queued at that point.

Three sticky status flags and programmable interrupt enables drive a single interrupt line:
- Overrun is cleared by dropping `fifo_en`.
- Timeout is cleared by dropping `rx_en`.
- Service request follows the FIFO fill level against a selectable watermark.

The read port has the following back-pressure rules:
- `rd_valid` is high while the FIFO holds an entry.
- An entry is removed on every clock edge where `rd_valid` and `rd_ready` are both high.
- The port may hold `rd_ready` high indefinitely.
- While `rd_valid` is low, `rd_ready` has no effect.

Top module: `ircap_rx`

## Requirements
- R1: With prescaler reload value D, a measurement of an interval of L clocks between two accepted edges stores floor((L-1)/(D+1)) shifted right by two in bits 15:0 of the read word.
- R2: Bit 16 of the read word is the input level during the measured interval (1 = high). Bit 17 is 1 whenever `rd_valid` is high, and the whole word is zero when `rd_valid` is low.
- R3: `edge_sel` bit 0 enables falling edges and bit 1 enables rising edges, so 0 ignores all edges and 3 uses both. The first enabled edge after `rx_en` rises only starts the timer. Every later enabled edge pushes a measurement and restarts the timer.
- R4: An input level change lasting `filt_count` clocks or fewer is ignored. A change lasting `filt_count+1` clocks or more is accepted, and a value of 0 passes every change.
- R5: `busy` is high from a start edge until the measurement ends by timeout or `rx_en` falls. While `rx_en` is low, no entries are produced.
- R6: When the timer passes its maximum, `busy` falls and `tmo_flag` sets. Unless `no_ovf_load` is 1, an entry whose low 17 bits are all ones (word 0x0003FFFF) is pushed.
- R7: The FIFO holds DEPTH entries (default 8) and returns them oldest first. A measurement arriving while it is full and not being read is dropped, and `ovr_flag` sets.
- R8: With `wm_not_empty` = 0, `srq` is high when at least DEPTH/2 entries are held. With `wm_not_empty` = 1, `srq` is high whenever at least one entry is held.
- R9: `ovr_flag` stays set while `fifo_en` stays high, even after the FIFO is read empty. A low `fifo_en` clears it and empties the FIFO.
- R10: `tmo_flag` stays set while `rx_en` stays high. A low `rx_en` clears it.
- R11: `irq` = (`ovr_flag` & `ie_ovr`) | (`tmo_flag` & `ie_tmo`) | (`srq` & `ie_srq`).
- R12: After reset, `rd_valid`, `rd_data`, `busy`, all flags and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared envelope (asynchronous) |
| rx_en | input | 1 | Receiver enable; low clears timer and timeout flag |
| fifo_en | input | 1 | FIFO enable; low empties FIFO and clears overrun flag |
| edge_sel | input | 2 | Bit 0 falling, bit 1 rising edge enable |
| filt_count | input | FILT_W | Glitch filter length in clocks, 0 = off |
| clk_div | input | DIV_W | Prescaler reload value |
| no_ovf_load | input | 1 | Suppress the timeout marker entry |
| wm_not_empty | input | 1 | Service request at non-empty instead of half full |
| ie_ovr | input | 1 | Overrun interrupt enable |
| ie_tmo | input | 1 | Timeout interrupt enable |
| ie_srq | input | 1 | Service-request interrupt enable |
| rd_data | output | 32 | Read word: bit 17 valid, bit 16 level, bits 15:0 width |
| rd_valid | output | 1 | FIFO holds an entry |
| rd_ready | input | 1 | Consumer takes the entry on this edge |
| busy | output | 1 | Measurement in progress |
| tmo_flag | output | 1 | Sticky timeout flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| srq | output | 1 | FIFO service request |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take for granted that `clk_div`, `filt_count` and `edge_sel` are only changed while `rx_en` is low. They also assume `ir_in` is an ordinary asynchronous level that the two-stage synchroniser absorbs. The stimulus reprograms the block only between trials, with `rx_en` held low, and then waits for the synchroniser and filter to settle before enabling. Input toggles are driven away from the sampling edge, so the interval seen by the timer equals the interval driven. The bench can therefore predict each stored width from R1 by arithmetic.

// File: rtl/ircap_pkg.sv
package ircap_pkg;
  localparam int ENTRY_W = 17;
  localparam int FIELD_W = 16;
  localparam logic [ENTRY_W-1:0] TMO_MARK = '1;

  typedef struct packed {
    logic               level;
    logic [FIELD_W-1:0] width;
  } ircap_entry_t;
endpackage

// File: rtl/ircap_filter.sv
module ircap_filter #(
  parameter int FILT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw,
  input  logic [FILT_W-1:0] filt_count,
  output logic              level
);
  logic [FILT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (raw == level) begin
      run_cnt <= '0;
    end else if (run_cnt >= filt_count) begin
      level   <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + FILT_W'(1);
    end
  end

  // R4: with the filter off, a change reaches the output one edge later
  a_r4_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_count == '0 && raw != level) |=> (level == $past(raw)));
endmodule

// File: rtl/ircap_timer.sv
module ircap_timer
  import ircap_pkg::*;
#(
  parameter int TMR_W = 18,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             level,
  input  logic [1:0]       edge_sel,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             no_ovf_load,
  output logic             push,
  output ircap_entry_t     push_data,
  output logic             busy,
  output logic             tmo_evt
);
  logic             prev_level;
  logic             running;
  logic [TMR_W-1:0] timer;
  logic [DIV_W-1:0] presc;
  logic             rise, fall, hit, tick, ovf;

  assign rise    = level & ~prev_level;
  assign fall    = ~level & prev_level;
  assign hit     = rx_en && ((edge_sel[0] && fall) || (edge_sel[1] && rise));
  assign tick    = running && (presc == '0);
  assign ovf     = rx_en && tick && (timer == '1) && !hit;
  assign tmo_evt = ovf;
  assign busy    = running;

  always_comb begin
    push = (hit && running) || (ovf && !no_ovf_load);
    if (hit) begin
      push_data.level = prev_level;
      push_data.width = FIELD_W'(timer >> 2);
    end else begin
      push_data = TMO_MARK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_level <= 1'b0;
      running    <= 1'b0;
      timer      <= '0;
      presc      <= '0;
    end else begin
      prev_level <= level;
      if (!rx_en) begin
        running <= 1'b0;
        timer   <= '0;
        presc   <= '0;
      end else if (hit) begin
        running <= 1'b1;
        timer   <= '0;
        presc   <= clk_div;
      end else if (ovf) begin
        running <= 1'b0;
        timer   <= '0;
      end else if (tick) begin
        timer <= timer + TMR_W'(1);
        presc <= clk_div;
      end else if (running) begin
        presc <= presc - DIV_W'(1);
      end
    end
  end

  // R5: a disabled receiver never keeps a measurement running
  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy);
  // R6: a timeout ends the measurement
  a_r6_tmo_stops: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !busy);
endmodule

// File: rtl/ircap_fifo.sv
module ircap_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 17,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign do_pop  = en && pop && (count != '0);
  assign do_push = en && push && (!full || do_pop);
  assign drop    = en && push && full && !do_pop;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (!en) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  // R7: a dropped write leaves the fill level untouched
  a_r7_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (count == $past(count)));
  // R7: fill level never exceeds the depth
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/ircap_rx.sv
module ircap_rx
  import ircap_pkg::*;
#(
  parameter int TMR_W  = 18,
  parameter int DIV_W  = 16,
  parameter int FILT_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              rx_en,
  input  logic              fifo_en,
  input  logic [1:0]        edge_sel,
  input  logic [FILT_W-1:0] filt_count,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              no_ovf_load,
  input  logic              wm_not_empty,
  input  logic              ie_ovr,
  input  logic              ie_tmo,
  input  logic              ie_srq,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              busy,
  output logic              tmo_flag,
  output logic              ovr_flag,
  output logic              srq,
  output logic              irq
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic         s_meta, s_sync, level;
  logic         push, tmo_evt, drop;
  ircap_entry_t push_data;
  logic [ENTRY_W-1:0] head;
  logic [CW-1:0]      count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
    end else begin
      s_meta <= ir_in;
      s_sync <= s_meta;
    end
  end

  ircap_filter #(.FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(s_sync), .filt_count(filt_count), .level(level)
  );

  ircap_timer #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .level(level), .edge_sel(edge_sel),
    .clk_div(clk_div), .no_ovf_load(no_ovf_load), .push(push),
    .push_data(push_data), .busy(busy), .tmo_evt(tmo_evt)
  );

  ircap_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .en(fifo_en), .push(push), .wdata(push_data),
    .pop(rd_ready), .rdata(head), .count(count), .drop(drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (!rx_en)        tmo_flag <= 1'b0;
      else if (tmo_evt)  tmo_flag <= 1'b1;
      if (!fifo_en)      ovr_flag <= 1'b0;
      else if (drop)     ovr_flag <= 1'b1;
    end
  end

  assign rd_valid = (count != '0);
  assign rd_data  = rd_valid ? {14'd0, 1'b1, head} : 32'd0;
  assign srq      = wm_not_empty ? (count != '0) : (count >= CW'(HALF));
  assign irq      = (ovr_flag & ie_ovr) | (tmo_flag & ie_tmo) | (srq & ie_srq);

  // R9: overrun survives reads while the FIFO stays enabled
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && fifo_en) |=> ovr_flag);
  // R10: timeout survives while the receiver stays enabled
  a_r10_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && rx_en) |=> tmo_flag);
endmodule

// File: tb/ircap_rx_test.sv
`timescale 1ns/1ps
module ircap_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b0, rx_en = 1'b0, fifo_en = 1'b0;
  logic [1:0] edge_sel = 2'd3;
  logic [7:0] filt_count = '0;
  logic [3:0] clk_div = '0;
  logic no_ovf_load = 1'b0, wm_not_empty = 1'b0;
  logic ie_ovr = 1'b0, ie_tmo = 1'b0, ie_srq = 1'b0, rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic rd_valid, busy, tmo_flag, ovr_flag, srq, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ircap_rx #(.TMR_W(8), .DIV_W(4), .FILT_W(8), .DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .rx_en(rx_en), .fifo_en(fifo_en),
    .edge_sel(edge_sel), .filt_count(filt_count), .clk_div(clk_div),
    .no_ovf_load(no_ovf_load), .wm_not_empty(wm_not_empty), .ie_ovr(ie_ovr),
    .ie_tmo(ie_tmo), .ie_srq(ie_srq), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .busy(busy), .tmo_flag(tmo_flag), .ovr_flag(ovr_flag),
    .srq(srq), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_word(output logic [31:0] w);
    w = rd_data;
    rd_ready = 1'b1;
    tick(1);
    rd_ready = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input logic lvl, input int len, input int dv);
    int t;
    t = (len - 1) / (dv + 1);
    return {14'd0, 1'b1, lvl, 16'(t >> 2)};
  endfunction

  // bring receiver up with the input settled at a given level
  task automatic arm(input logic start_lvl, input int f);
    rx_en = 1'b0;
    ir_in = start_lvl;
    tick(f + 8);
    rx_en = 1'b1;
    tick(2);
  endtask

  task automatic pair_trial(input int dv, input int l1, input int l2, input int f);
    logic [31:0] w;
    clk_div = 4'(dv);
    filt_count = 8'(f);
    edge_sel = 2'd3;
    arm(1'b0, f);
    ir_in = 1'b1; tick(l1);
    ir_in = 1'b0; tick(l2);
    ir_in = 1'b1; tick(f + 6);
    check("R5 busy while measuring", {31'd0, busy}, 32'd1);
    pop_word(w); check("R1 R2 high interval", w, exp_word(1'b1, l1, dv));
    pop_word(w); check("R1 R2 low interval", w, exp_word(1'b0, l2, dv));
    check("R2 empty word", rd_data, 32'd0);
    rx_en = 1'b0; tick(1);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R12 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R12 rd_data", rd_data, 32'd0);
    check("R12 flags", {27'd0, busy, tmo_flag, ovr_flag, srq, irq}, 32'd0);
    fifo_en = 1'b1;

    // R1 R2 sweep over prescaler and widths, filters off and on
    for (int dv = 0; dv < 4; dv++)
      for (int l = 8; l <= 44; l += 4)
        pair_trial(dv, l, l + 3, 0);
    for (int f = 2; f <= 5; f += 3)
      for (int l = 10; l <= 30; l += 5)
        pair_trial(1, l, l + 2, f);

    // R3 rising edges only: one full period, ends low
    clk_div = 0; filt_count = 0; edge_sel = 2'd2;
    arm(1'b0, 0);
    ir_in = 1'b1; tick(9); ir_in = 1'b0; tick(14); ir_in = 1'b1; tick(6);
    pop_word(w); check("R3 rising period", w, exp_word(1'b0, 23, 0));
    check("R3 rising single entry", {31'd0, rd_valid}, 32'd0);
    // R3 falling edges only
    edge_sel = 2'd1;
    arm(1'b1, 0);
    ir_in = 1'b0; tick(11); ir_in = 1'b1; tick(17); ir_in = 1'b0; tick(6);
    pop_word(w); check("R3 falling period", w, exp_word(1'b1, 28, 0));
    check("R3 falling single entry", {31'd0, rd_valid}, 32'd0);
    // R3 no edges
    edge_sel = 2'd0;
    arm(1'b0, 0);
    for (int i = 0; i < 6; i++) begin ir_in = ~ir_in; tick(7); end
    check("R3 none busy", {31'd0, busy}, 32'd0);
    check("R3 none entries", {31'd0, rd_valid}, 32'd0);

    // R4 glitch rejection boundary
    edge_sel = 2'd3; filt_count = 8'd3;
    arm(1'b0, 3);
    ir_in = 1'b1; tick(3); ir_in = 1'b0; tick(12);
    check("R4 short pulse ignored busy", {31'd0, busy}, 32'd0);
    check("R4 short pulse ignored fifo", {31'd0, rd_valid}, 32'd0);
    ir_in = 1'b1; tick(4); ir_in = 1'b0; tick(12);
    check("R4 long pulse accepted", {31'd0, busy}, 32'd1);
    pop_word(w); check("R4 long pulse width", w, exp_word(1'b1, 4, 0));
    rx_en = 1'b0; tick(2);
    check("R5 disable stops busy", {31'd0, busy}, 32'd0);
    filt_count = 0;

    // R7 overrun, R9 sticky and clear, R11 overrun interrupt
    arm(1'b0, 0);
    ir_in = 1'b1;
    for (int i = 0; i < 9; i++) begin tick(5 + 2 * i); ir_in = ~ir_in; end
    tick(6);
    rx_en = 1'b0;
    check("R7 overrun set", {31'd0, ovr_flag}, 32'd1);
    ie_ovr = 1'b1; tick(1);
    check("R11 overrun irq", {31'd0, irq}, 32'd1);
    ie_ovr = 1'b0; tick(1);
    check("R11 overrun masked", {31'd0, irq}, 32'd0);
    for (int j = 0; j < 8; j++) begin
      pop_word(w);
      check("R7 oldest first", w, exp_word((j % 2) == 0, 5 + 2 * j, 0));
    end
    tick(3);
    check("R7 ninth dropped", {31'd0, rd_valid}, 32'd0);
    check("R9 overrun sticky after read", {31'd0, ovr_flag}, 32'd1);
    fifo_en = 1'b0; tick(1); fifo_en = 1'b1; tick(1);
    check("R9 overrun cleared", {31'd0, ovr_flag}, 32'd0);

    // R8 watermark, R11 service interrupt, R9 flush
    wm_not_empty = 1'b0; ie_srq = 1'b1;
    arm(1'b0, 0);
    ir_in = 1'b1;
    for (int n = 1; n <= 5; n++) begin
      tick(6); ir_in = ~ir_in; tick(6);
      check("R8 half full watermark", {31'd0, srq}, {31'd0, n >= 4});
      check("R11 service irq", {31'd0, irq}, {31'd0, n >= 4});
    end
    rx_en = 1'b0;
    ie_srq = 1'b0; tick(1);
    check("R11 service masked", {31'd0, irq}, 32'd0);
    fifo_en = 1'b0; tick(1); fifo_en = 1'b1; tick(1);
    check("R9 flush empties", {31'd0, rd_valid}, 32'd0);
    wm_not_empty = 1'b1;
    arm(1'b0, 0);
    check("R8 empty no request", {31'd0, srq}, 32'd0);
    ir_in = 1'b1; tick(6); ir_in = 1'b0; tick(6);
    check("R8 not-empty watermark", {31'd0, srq}, 32'd1);
    rx_en = 1'b0;
    pop_word(w);
    check("R8 request drops when empty", {31'd0, srq}, 32'd0);
    wm_not_empty = 1'b0;

    // R6 timeout marker, R10 sticky, R11 timeout interrupt
    clk_div = 4'd1; ie_tmo = 1'b1;
    arm(1'b0, 0);
    ir_in = 1'b1; tick(530);
    check("R6 marker word", rd_data, 32'h0003FFFF);
    check("R6 timeout flag", {31'd0, tmo_flag}, 32'd1);
    check("R6 busy cleared", {31'd0, busy}, 32'd0);
    check("R11 timeout irq", {31'd0, irq}, 32'd1);
    pop_word(w);
    tick(100);
    check("R10 timeout sticky", {31'd0, tmo_flag}, 32'd1);
    check("R6 single marker", {31'd0, rd_valid}, 32'd0);
    rx_en = 1'b0; tick(1); rx_en = 1'b1; tick(1);
    check("R10 timeout cleared", {31'd0, tmo_flag}, 32'd0);
    no_ovf_load = 1'b1;
    ir_in = 1'b0; tick(530);
    check("R6 suppressed flag", {31'd0, tmo_flag}, 32'd1);
    check("R6 suppressed marker", {31'd0, rd_valid}, 32'd0);
    rx_en = 1'b0; tick(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule